// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs complete register-level I2C transactions on a byte engine that reports each finished bus step through a completion flag and an 8-bit status code. A host issues one command: a 7-bit device address, a register offset of zero to `MAX_ALEN` bytes, an operation (probe, write or read) and a byte count. The sequencer then writes the engine's control and data registers step by step. After each step it waits for completion and compares the reported status with the code that step should produce.

Write data enters on a valid/ready stream. A byte is taken only in the cycle its transmit step is issued, so a slow source simply stalls the transaction. Read data leaves on a valid/ready stream. The sequencer holds each received byte stable until the sink accepts it, and it does not start the next receive step before then. When the STOP step settles, `done` pulses for one cycle. At that point `err_word` is zero on success, or holds a packed diagnostic word for the first step that failed.

Top module: `i2c_xact_seq`

## Requirements
- R1: A read command issues, in this order: START (status 0x08), the device address with the direction bit 0 (0x18), each register byte most significant first (0x28 each), a second START with no STOP before it (0x10), the device address with the direction bit 1 (0x40), the receive steps, and STOP. The first control write after a command is accepted always carries START.
- R2: During a read, every receive step except the last sets the acknowledge bit (control bit 2, 0x04) and expects status 0x50. The last receive step clears that bit and expects 0x58.
- R3: A write command issues START, the device address with direction bit 0, the register bytes most significant first, and then every stream byte in arrival order, each expecting 0x28. It ends with STOP. Data-register writes occur only together with a control write that has neither START nor STOP set.
- R4: A probe issues START, the device address with direction bit 1, one receive step without acknowledge (0x58) and STOP. It delivers no byte on the read stream and succeeds only when every status matches.
- R5: After the first failing step, no further transfer step is issued, but STOP is still issued, and the first error word is kept even if STOP also fails.
- R6: The error word is {class[31:24], control[23:16], status[15:8], expected[7:0]}. The control field is the last control value written, with the flag bit (0x08) added when the flag was set. On a status mismatch the class is 0x01.
- R7: Each flag wait times out when its cycle count reaches `tmo_limit` before the flag is seen. A flag that arrives in that same cycle still counts as success. On a timeout the class is 0x02 and the status field holds the current engine status.
- R8: STOP is complete when the engine status reads 0xF8, whatever the flag does. If it is not reached in time, a timeout word with expected value 0xF8 is reported.
- R9: A register length of zero skips the register bytes, and a byte count of zero skips the data or receive phase.
- R10: The read stream holds `rd_valid` and `rd_data` stable until `rd_ready`. No engine write occurs while the sequencer is idle.
- R11: After reset the sequencer is idle and ready. `done` is a single-cycle pulse, and `err_word` is zero for a transaction in which every step matched.
- Control encodings: enable 0x40, START 0x20, STOP 0x10, flag 0x08, acknowledge 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | TMO_W | Cycle bound for every wait step |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_op | input | 2 | 0 probe, 1 write, 2 read |
| cmd_chip | input | 7 | Device address |
| cmd_reg | input | 8*MAX_ALEN | Register offset, low bytes used |
| cmd_alen | input | AL_W | Register offset length in bytes |
| cmd_len | input | LEN_W | Data byte count |
| wd_valid | input | 1 | Write byte offered |
| wd_ready | output | 1 | Write byte taken this cycle |
| wd_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Sink accepts received byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Transaction finished pulse |
| err_word | output | 32 | Zero or first error word |
| eng_ctrl_we | output | 1 | Control register write strobe |
| eng_ctrl | output | 8 | Control value written |
| eng_data_we | output | 1 | Data register write strobe |
| eng_wdata | output | 8 | Byte to transmit |
| eng_flag | input | 1 | Engine step-complete flag |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Engine received byte |

## Verification
The interesting collision is between a flag arrival and a wait expiry in the same cycle. The bench sets the engine latency so that the flag becomes visible exactly when the wait counter equals `tmo_limit`, and expects a clean transaction. One cycle less of limit must instead yield the timeout word 0x0260F808 for the START step. A second overlap, the STOP step timing out after an earlier failure, is judged by checking that the earlier word survives.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {OP_PROBE = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2} op_e;
  typedef enum logic [2:0] {
    PH_START, PH_ADDRW, PH_REG, PH_RSTART, PH_ADDRR, PH_WDATA, PH_RDATA, PH_STOP
  } phase_e;
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_RDOUT, S_DONE} seq_st_e;

  localparam logic [7:0] CTL_EN   = 8'h40;
  localparam logic [7:0] CTL_STA  = 8'h20;
  localparam logic [7:0] CTL_STO  = 8'h10;
  localparam logic [7:0] CTL_FLAG = 8'h08;
  localparam logic [7:0] CTL_ACK  = 8'h04;

  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK = 8'h18;
  localparam logic [7:0] ST_DW_ACK = 8'h28;
  localparam logic [7:0] ST_AR_ACK = 8'h40;
  localparam logic [7:0] ST_DR_ACK = 8'h50;
  localparam logic [7:0] ST_DR_NAK = 8'h58;
  localparam logic [7:0] ST_IDLE   = 8'hF8;

  localparam logic [7:0] CLS_BAD = 8'h01;
  localparam logic [7:0] CLS_TMO = 8'h02;
endpackage

// File: rtl/i2c_seq_step.sv
module i2c_seq_step import i2c_seq_pkg::*; (
  input  phase_e     phase,
  input  logic [6:0] chip,
  input  logic [7:0] reg_byte,
  input  logic [7:0] wd_byte,
  input  logic       last_rd,
  output logic [7:0] ctrl,
  output logic [7:0] exp_st,
  output logic [7:0] tx,
  output logic       send
);
  always_comb begin
    ctrl   = CTL_EN;
    exp_st = ST_DW_ACK;
    tx     = 8'h00;
    send   = 1'b0;
    case (phase)
      PH_START:  begin ctrl = CTL_EN | CTL_STA; exp_st = ST_START; end
      PH_RSTART: begin ctrl = CTL_EN | CTL_STA; exp_st = ST_RSTART; end
      PH_ADDRW:  begin tx = {chip, 1'b0}; send = 1'b1; exp_st = ST_AW_ACK; end
      PH_ADDRR:  begin tx = {chip, 1'b1}; send = 1'b1; exp_st = ST_AR_ACK; end
      PH_REG:    begin tx = reg_byte; send = 1'b1; end
      PH_WDATA:  begin tx = wd_byte; send = 1'b1; end
      PH_RDATA:  begin
        ctrl   = last_rd ? CTL_EN : (CTL_EN | CTL_ACK);
        exp_st = last_rd ? ST_DR_NAK : ST_DR_ACK;
      end
      default:   begin ctrl = CTL_EN | CTL_STO; exp_st = ST_IDLE; end
    endcase
  end
endmodule

// File: rtl/i2c_seq_wait.sv
module i2c_seq_wait import i2c_seq_pkg::*; #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             is_stop,
  input  logic             flag,
  input  logic [7:0]       status,
  input  logic [7:0]       exp_st,
  input  logic [TMO_W-1:0] limit,
  output logic             ok,
  output logic             bad,
  output logic             tout
);
  logic [TMO_W-1:0] cnt;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!active)        cnt <= '0;
    else if (cnt != '1)      cnt <= cnt + 1'b1;
  end

  always_comb begin
    hit  = is_stop ? (status == ST_IDLE) : flag;
    ok   = active && hit && (is_stop || status == exp_st);
    bad  = active && !is_stop && flag && (status != exp_st);
    tout = active && !hit && (cnt >= limit);
  end
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq import i2c_seq_pkg::*; #(
  parameter  int LEN_W    = 8,
  parameter  int TMO_W    = 16,
  parameter  int MAX_ALEN = 4,
  localparam int AL_W     = $clog2(MAX_ALEN + 1),
  localparam int REG_W    = 8 * MAX_ALEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       cmd_chip,
  input  logic [REG_W-1:0] cmd_reg,
  input  logic [AL_W-1:0]  cmd_alen,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [7:0]       wd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [31:0]      err_word,
  output logic             eng_ctrl_we,
  output logic [7:0]       eng_ctrl,
  output logic             eng_data_we,
  output logic [7:0]       eng_wdata,
  input  logic             eng_flag,
  input  logic [7:0]       eng_status,
  input  logic [7:0]       eng_rdata
);
  seq_st_e          st;
  phase_e           ph;
  op_e              op_q;
  logic [6:0]       chip_q;
  logic [REG_W-1:0] reg_q;
  logic [AL_W-1:0]  ridx;
  logic [LEN_W-1:0] dcnt;
  logic [7:0]       last_ctrl, rd_q, reg_byte;
  logic [31:0]      err_q;
  logic [7:0]       step_ctrl, step_exp, step_tx;
  logic             step_send, w_ok, w_bad, w_tout, issue_go;

  always_comb reg_byte = 8'(reg_q >> (8 * (32'(ridx) - 32'd1)));

  i2c_seq_step u_step (
    .phase(ph), .chip(chip_q), .reg_byte(reg_byte), .wd_byte(wd_data),
    .last_rd(dcnt == LEN_W'(1)), .ctrl(step_ctrl), .exp_st(step_exp),
    .tx(step_tx), .send(step_send)
  );

  i2c_seq_wait #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(st == S_WAIT), .is_stop(ph == PH_STOP),
    .flag(eng_flag), .status(eng_status), .exp_st(step_exp), .limit(tmo_limit),
    .ok(w_ok), .bad(w_bad), .tout(w_tout)
  );

  // Phase that follows the register offset bytes
  function automatic phase_e after_reg(op_e o, logic [LEN_W-1:0] n);
    if (o == OP_READ)  return PH_RSTART;
    if (n != '0)       return PH_WDATA;
    return PH_STOP;
  endfunction

  always_comb begin
    cmd_ready   = (st == S_IDLE);
    wd_ready    = (st == S_ISSUE) && (ph == PH_WDATA);
    issue_go    = (st == S_ISSUE) && ((ph != PH_WDATA) || wd_valid);
    eng_ctrl_we = issue_go;
    eng_ctrl    = step_ctrl;
    eng_data_we = issue_go && step_send;
    eng_wdata   = step_tx;
    rd_valid    = (st == S_RDOUT);
    rd_data     = rd_q;
    done        = (st == S_DONE);
    err_word    = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= PH_START;  op_q <= OP_PROBE;
      chip_q <= '0;  reg_q <= '0;  ridx <= '0;  dcnt <= '0;
      last_ctrl <= '0;  rd_q <= '0;  err_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q   <= op_e'(cmd_op);
          chip_q <= cmd_chip;
          reg_q  <= cmd_reg;
          ridx   <= cmd_alen;
          dcnt   <= (op_e'(cmd_op) == OP_PROBE) ? LEN_W'(1) : cmd_len;
          err_q  <= '0;
          ph     <= PH_START;
          st     <= S_ISSUE;
        end
        S_ISSUE: if (issue_go) begin
          last_ctrl <= step_ctrl;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (w_ok) begin
            st <= S_ISSUE;
            case (ph)
              PH_START:  ph <= (op_q == OP_PROBE) ? PH_ADDRR : PH_ADDRW;
              PH_ADDRW:  ph <= (ridx != '0) ? PH_REG : after_reg(op_q, dcnt);
              PH_REG: begin
                ridx <= ridx - 1'b1;
                ph   <= (ridx == AL_W'(1)) ? after_reg(op_q, dcnt) : PH_REG;
              end
              PH_RSTART: ph <= PH_ADDRR;
              PH_ADDRR:  ph <= (dcnt != '0) ? PH_RDATA : PH_STOP;
              PH_WDATA: begin
                dcnt <= dcnt - 1'b1;
                ph   <= (dcnt == LEN_W'(1)) ? PH_STOP : PH_WDATA;
              end
              PH_RDATA: begin
                dcnt <= dcnt - 1'b1;
                ph   <= (dcnt == LEN_W'(1)) ? PH_STOP : PH_RDATA;
                if (op_q != OP_PROBE) begin
                  rd_q <= eng_rdata;
                  st   <= S_RDOUT;
                end
              end
              default:   st <= S_DONE;
            endcase
          end else if (w_bad || w_tout) begin
            if (err_q == '0)
              err_q <= {w_tout ? CLS_TMO : CLS_BAD,
                        last_ctrl | (eng_flag ? CTL_FLAG : 8'h00),
                        eng_status, step_exp};
            if (ph == PH_STOP) st <= S_DONE;
            else begin
              ph <= PH_STOP;
              st <= S_ISSUE;
            end
          end
        end
        S_RDOUT: if (rd_ready) st <= S_ISSUE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_xact_seq_chk.sv
module i2c_xact_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        wd_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [7:0]  rd_data,
  input logic        done,
  input logic [31:0] err_word,
  input logic        eng_ctrl_we,
  input logic [7:0]  eng_ctrl,
  input logic        eng_data_we
);
  AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> eng_ctrl_we && eng_ctrl[5] && !eng_ctrl[4]); // R1
  AST_DATA_WITH_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    eng_data_we |-> eng_ctrl_we && !eng_ctrl[5] && !eng_ctrl[4]); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !eng_ctrl_we && !rd_valid && !wd_ready); // R10
  AST_ERR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_word != 32'h0 |-> err_word[31:24] == 8'h01 || err_word[31:24] == 8'h02); // R6
  AST_MISMATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && err_word[31:24] == 8'h01 |-> err_word[19]); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
endmodule

bind i2c_xact_seq i2c_xact_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .wd_ready(wd_ready), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .done(done), .err_word(err_word), .eng_ctrl_we(eng_ctrl_we), .eng_ctrl(eng_ctrl),
  .eng_data_we(eng_data_we)
);

// File: tb/tb_i2c_xact_seq.sv
module tb_i2c_xact_seq;
  localparam logic [6:0]  DEV  = 7'h52;
  localparam logic [31:0] REGV = 32'h1A2B3C4D;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] tmo_limit = 16'd200;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [6:0]  cmd_chip = DEV;
  logic [31:0] cmd_reg = REGV;
  logic [2:0]  cmd_alen = 3'd0;
  logic [7:0]  cmd_len = 8'd0;
  logic        wd_valid, wd_ready, rd_valid, rd_ready, done;
  logic [7:0]  wd_data, rd_data;
  logic [31:0] err_word;
  logic        eng_ctrl_we, eng_data_we, eng_flag;
  logic [7:0]  eng_ctrl, eng_wdata, eng_status, eng_rdata;

  i2c_xact_seq dut (.*);

  integer tests = 0, fails = 0, cyc = 0;
  logic   clr = 1'b0, bp = 1'b0, stop_hang = 1'b0;
  integer hang_step = -1, eng_dly = 2;

  // engine model and stream endpoints
  logic [7:0] nxt_st, tx_log [64], rd_log [64];
  logic       pend, is_stop, in_x;
  integer     dly, wcount, tx_n, rd_n, rcnt, widx, starts, stops, acks;

  assign wd_data  = 8'h30 + 8'(widx);
  assign wd_valid = bp ? cyc[0] : 1'b1;
  assign rd_ready = bp ? (cyc[1] & cyc[0]) : 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_flag <= 1'b0; eng_status <= 8'hF8; eng_rdata <= 8'h00;
      pend <= 1'b0; is_stop <= 1'b0; in_x <= 1'b0; dly <= 0; nxt_st <= 8'h00;
      wcount <= 0; tx_n <= 0; rd_n <= 0; rcnt <= 0; widx <= 0;
      starts <= 0; stops <= 0; acks <= 0;
    end else if (clr) begin
      wcount <= 0; tx_n <= 0; rd_n <= 0; rcnt <= 0; widx <= 0;
      starts <= 0; stops <= 0; acks <= 0;
    end else begin
      if (wd_valid && wd_ready) widx <= widx + 1;
      if (rd_valid && rd_ready) begin rd_log[rd_n] <= rd_data; rd_n <= rd_n + 1; end
      if (eng_ctrl_we) begin
        eng_flag <= 1'b0;
        wcount   <= wcount + 1;
        dly      <= eng_dly;
        is_stop  <= eng_ctrl[4];
        pend     <= (wcount != hang_step) && !(eng_ctrl[4] && stop_hang);
        if (eng_data_we) begin tx_log[tx_n] <= eng_wdata; tx_n <= tx_n + 1; end
        if (eng_ctrl[4]) begin
          nxt_st <= 8'hF8; in_x <= 1'b0; stops <= stops + 1;
        end else if (eng_ctrl[5]) begin
          nxt_st <= in_x ? 8'h10 : 8'h08; in_x <= 1'b1; starts <= starts + 1;
        end else if (!eng_data_we) begin
          nxt_st    <= eng_ctrl[2] ? 8'h50 : 8'h58;
          acks      <= acks + (eng_ctrl[2] ? 1 : 0);
          eng_rdata <= 8'hA0 + 8'(rcnt);
          rcnt      <= rcnt + 1;
        end else if (eng_status == 8'h08 || eng_status == 8'h10) begin
          if (eng_wdata[7:1] == DEV) nxt_st <= eng_wdata[0] ? 8'h40 : 8'h18;
          else                       nxt_st <= eng_wdata[0] ? 8'h48 : 8'h20;
        end else nxt_st <= 8'h28;
      end else if (pend) begin
        if (dly == 0) begin
          pend <= 1'b0; eng_status <= nxt_st;
          if (!is_stop) eng_flag <= 1'b1;
        end else dly <= dly - 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  integer t_cyc;
  task automatic run(input logic [1:0] op, input logic [6:0] chip, input int alen, input int len);
    @(negedge clk);
    clr = 1'b1; cmd_op = op; cmd_chip = chip; cmd_alen = 3'(alen); cmd_len = 8'(len);
    cmd_valid = 1'b1; t_cyc = cyc;
    @(negedge clk);
    clr = 1'b0; cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    t_cyc = cyc - t_cyc;
  endtask

  // compare observed traffic with the sequence computed from the requirements
  task automatic flow(input string req, input logic [1:0] op, input int alen, input int len);
    logic [7:0] e [64];
    int n = 0, bad = 0;
    if (op == 2'd0) begin e[n] = {DEV, 1'b1}; n = n + 1; end
    else begin
      e[n] = {DEV, 1'b0}; n = n + 1;
      for (int i = alen - 1; i >= 0; i--) begin e[n] = REGV[8*i +: 8]; n = n + 1; end
      if (op == 2'd1) for (int i = 0; i < len; i++) begin e[n] = 8'h30 + 8'(i); n = n + 1; end
      else begin e[n] = {DEV, 1'b1}; n = n + 1; end
    end
    check({req, " err"}, err_word, 32'h0);
    check({req, " tx count"}, tx_n, n);
    for (int i = 0; i < n && i < tx_n; i++) if (tx_log[i] !== e[i]) bad = bad + 1;
    check({req, " tx bytes"}, bad, 0);
    check({req, " starts/stops"}, {starts[15:0], stops[15:0]}, {(op == 2'd2) ? 16'd2 : 16'd1, 16'd1});
    if (op == 2'd2) begin
      bad = 0;
      for (int i = 0; i < len && i < rd_n; i++) if (rd_log[i] !== 8'hA0 + 8'(i)) bad = bad + 1;
      check({req, " rd count"}, rd_n, len);
      check({req, " rd data"}, bad, 0);
      check("R2 ack bits", acks, (len > 0) ? len - 1 : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1; tests = tests + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset ready", {31'd0, cmd_ready}, 32'd1);
    check("R11 reset quiet", {30'd0, done, eng_ctrl_we}, 32'd0);
    rst_n = 1'b1;
    // sweep of offset lengths and byte counts
    for (int a = 0; a <= 4; a++)
      for (int l = 0; l <= 3; l++) begin
        run(2'd1, DEV, a, l); flow((a == 0 || l == 0) ? "R9 write" : "R3 write", 2'd1, a, l);
        run(2'd2, DEV, a, l); flow((a == 0 || l == 0) ? "R9 read" : "R1 read", 2'd2, a, l);
      end
    // probe present and absent
    run(2'd0, DEV, 0, 0); flow("R4 probe", 2'd0, 0, 0);
    check("R4 probe no rd", rd_n, 0);
    run(2'd0, 7'h11, 0, 0);
    check("R4 probe absent", err_word, 32'h01484840);
    // wrong device on write: mismatch, skip, stop
    run(2'd1, 7'h11, 2, 2);
    check("R6 mismatch word", err_word, 32'h01482018);
    check("R5 skipped tx", tx_n, 1);
    check("R5 stop issued", stops, 1);
    // engine hangs on the register byte
    tmo_limit = 16'd20; hang_step = 2;
    run(2'd1, DEV, 1, 2);
    check("R7 timeout word", err_word, 32'h02401828);
    check("R7 waited limit", {31'd0, t_cyc >= 20}, 32'd1);
    check("R5 tx after timeout", tx_n, 2);
    hang_step = -1;
    // STOP never settles
    stop_hang = 1'b1;
    run(2'd1, DEV, 0, 0);
    check("R8 stop timeout", err_word, 32'h025018F8);
    stop_hang = 1'b0;
    run(2'd1, DEV, 0, 0);
    check("R8 stop ok", err_word, 32'h0);
    // flag arriving exactly at the limit wins
    tmo_limit = 16'(eng_dly + 1);
    run(2'd2, DEV, 1, 2); flow("R7 flag at limit", 2'd2, 1, 2);
    tmo_limit = 16'(eng_dly);
    run(2'd1, DEV, 0, 1);
    check("R7 one short", err_word, 32'h0260F808);
    check("R5 first kept", stops, 1);
    tmo_limit = 16'd200;
    // back-pressure on both streams
    bp = 1'b1;
    run(2'd2, DEV, 2, 3); flow("R10 read bp", 2'd2, 2, 3);
    run(2'd1, DEV, 1, 3); flow("R10 write bp", 2'd1, 1, 3);
    bp = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule